// File: doc/BRIEF.md
# Register Rename Map with Recovery Log

This block turns architectural register numbers into physical register numbers for an out-of-order core. Each accepted rename request reads the current physical mapping of two source operands, together with a ready flag from a per-physical-register scoreboard. If the request has a destination, the block takes a fresh physical register from a free pool, marks it not ready, points the architectural register at it, and reports both the new and the displaced physical register.

Every destination rename appends a record (sequence number, architectural register, new physical register, displaced physical register) to a circular recovery log. A commit for a completed sequence number retires records from the old end and returns their displaced registers to the pool. A squash retires records from the young end whose sequence number is above the squash point, putting the old mapping back and returning the new register to the pool. Both walks retire one record per clock and hold `busy_o` while active. A free-register count lets the requester see how much room is left.

Top module: `rn_rename_map`

## Requirements
- R1: After reset every architectural register i maps to physical register i, every physical register reads ready, the free count equals NUM_PHYS minus NUM_ARCH and `busy_o` is low.
- R2: An accepted request returns, for each source, the physical register the architectural register maps to before this request's own destination takes effect, with the ready flag of that physical register.
- R3: A destination rename returns the lowest-numbered free physical register as the new register and the previous mapping as the displaced register; the new register is removed from the pool, reads not ready afterwards, and becomes the mapping of the destination.
- R4: A write-back of a physical register makes it read ready from the next cycle on.
- R5: `free_count_o` gives the number of free physical registers; with a destination requested and a count of zero, `req_ready_o` is low, while a request without destination is still accepted.
- R6: A squash walks the log from youngest to oldest, one record per cycle, while the record's sequence number is greater than the squash number; each record restores its displaced mapping and frees its new register. `busy_o` is high from the cycle after the squash until the walk ends, and no rename is accepted in the squash cycle or during the walk.
- R7: A commit walks the log from oldest to youngest, one record per cycle, while the record's sequence number is at most the commit number, freeing each displaced register and leaving the map unchanged.
- R8: A commit has no effect when the log is empty or when its oldest record is younger than the commit number.
- R9: A commit presented in the same cycle as a squash, or while a squash walk is active, has no effect.
- R10: A squash against an empty log changes neither the map nor the free count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Rename request present |
| req_seq_i | input | SEQ_W | Sequence number of the request |
| req_src0_i | input | AW | First source architectural register |
| req_src1_i | input | AW | Second source architectural register |
| req_dst_valid_i | input | 1 | Request has a destination |
| req_dst_i | input | AW | Destination architectural register |
| req_ready_o | output | 1 | Request is accepted at the next edge if valid |
| src0_phys_o | output | PW | First source physical register |
| src0_rdy_o | output | 1 | First source operand ready |
| src1_phys_o | output | PW | Second source physical register |
| src1_rdy_o | output | 1 | Second source operand ready |
| dst_phys_o | output | PW | Newly allocated physical register |
| dst_prev_o | output | PW | Displaced physical register |
| wb_valid_i | input | 1 | Write-back marks a register ready |
| wb_phys_i | input | PW | Physical register written back |
| commit_valid_i | input | 1 | Commit request |
| commit_seq_i | input | SEQ_W | Newest completed sequence number |
| squash_valid_i | input | 1 | Squash request |
| squash_seq_i | input | SEQ_W | Last surviving sequence number |
| busy_o | output | 1 | A commit or squash walk is active |
| free_count_o | output | CW | Number of free physical registers |

## Verification
Renames are issued in chains where one request reads a register the previous one wrote, and where a request reads and writes the same register, which separates a read of the old mapping from a read of the new one. Write-backs between renames separate a scoreboard that is set from one that stays clear. Squashes that cut part of the log, the whole log and an empty log, and commits that retire, that hit a younger oldest record, that arrive together with a squash or that hit an empty log, are each followed by lookups and a free-count read, so a missed restore, a wrong freed register or a walk that should not happen all show at the ports. The pool is then drained to zero, which shows the lowest-first allocation order and the stall on a full pool.

// File: rtl/rn_pkg.sv
package rn_pkg;
  typedef enum logic [1:0] {
    WALK_IDLE   = 2'd0,
    WALK_SQUASH = 2'd1,
    WALK_COMMIT = 2'd2
  } walk_e;
endpackage

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int NUM_PHYS = 16,
  parameter int NUM_ARCH = 8,
  localparam int PW = $clog2(NUM_PHYS),
  localparam int CW = $clog2(NUM_PHYS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_i,
  output logic [PW-1:0] alloc_idx_o,
  input  logic          rel_i,
  input  logic [PW-1:0] rel_idx_i,
  output logic [CW-1:0] count_o,
  output logic          nonempty_o
);
  logic [NUM_PHYS-1:0] free_q;

  always_comb begin
    alloc_idx_o = '0;
    nonempty_o  = 1'b0;
    for (int i = 0; i < NUM_PHYS; i++) begin
      if (free_q[i] && !nonempty_o) begin
        alloc_idx_o = PW'(i);
        nonempty_o  = 1'b1;
      end
    end
  end

  always_comb begin
    count_o = '0;
    for (int i = 0; i < NUM_PHYS; i++) count_o = count_o + CW'(free_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PHYS; i++) free_q[i] <= (i >= NUM_ARCH);
    end else begin
      if (alloc_i) free_q[alloc_idx_o] <= 1'b0;
      if (rel_i)   free_q[rel_idx_i]   <= 1'b1;
    end
  end

  // R3: allocation only from the pool
  a_r3_alloc_from_pool: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> free_q[alloc_idx_o]);
  // R7: a register is never returned twice
  a_r7_no_double_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_i |-> !free_q[rel_idx_i]);
endmodule

// File: rtl/rn_scoreboard.sv
module rn_scoreboard #(
  parameter int NUM_PHYS = 16,
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic [PW-1:0] set_idx_i,
  input  logic          clr_i,
  input  logic [PW-1:0] clr_idx_i,
  input  logic [PW-1:0] rd0_idx_i,
  input  logic [PW-1:0] rd1_idx_i,
  output logic          rd0_o,
  output logic          rd1_o
);
  logic [NUM_PHYS-1:0] rdy_q;

  assign rd0_o = rdy_q[rd0_idx_i];
  assign rd1_o = rdy_q[rd1_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q <= '1;
    end else begin
      if (set_i) rdy_q[set_idx_i] <= 1'b1;
      if (clr_i) rdy_q[clr_idx_i] <= 1'b0;
    end
  end

  // R3: a fresh destination reads not ready afterwards
  a_r3_clear_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(set_i && set_idx_i == clr_idx_i)) |=> !rdy_q[$past(clr_idx_i)]);
  // R4: a write-back is visible on the next cycle
  a_r4_set_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !(clr_i && set_idx_i == clr_idx_i)) |=> rdy_q[$past(set_idx_i)]);
endmodule

// File: rtl/rn_history.sv
module rn_history #(
  parameter int DEPTH = 16,
  parameter int SEQ_W = 8,
  parameter int AW    = 3,
  parameter int PW    = 4,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int NW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [SEQ_W-1:0] push_seq_i,
  input  logic [AW-1:0]    push_arch_i,
  input  logic [PW-1:0]    push_new_i,
  input  logic [PW-1:0]    push_prev_i,
  input  logic             pop_old_i,
  input  logic             pop_young_i,
  output logic [SEQ_W-1:0] old_seq_o,
  output logic [PW-1:0]    old_prev_o,
  output logic [SEQ_W-1:0] young_seq_o,
  output logic [AW-1:0]    young_arch_o,
  output logic [PW-1:0]    young_new_o,
  output logic [PW-1:0]    young_prev_o,
  output logic             empty_o,
  output logic             full_o
);
  logic [SEQ_W-1:0] seq_q  [DEPTH];
  logic [AW-1:0]    arch_q [DEPTH];
  logic [PW-1:0]    new_q  [DEPTH];
  logic [PW-1:0]    prev_q [DEPTH];
  logic [IW-1:0]    head_q, tail_q, young_idx;
  logic [NW-1:0]    cnt_q;

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + IW'(1);
  endfunction

  assign young_idx    = (tail_q == '0) ? IW'(DEPTH - 1) : tail_q - IW'(1);
  assign empty_o      = (cnt_q == '0);
  assign full_o       = (cnt_q == NW'(DEPTH));
  assign old_seq_o    = seq_q[head_q];
  assign old_prev_o   = prev_q[head_q];
  assign young_seq_o  = seq_q[young_idx];
  assign young_arch_o = arch_q[young_idx];
  assign young_new_o  = new_q[young_idx];
  assign young_prev_o = prev_q[young_idx];

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      seq_q[tail_q]  <= push_seq_i;
      arch_q[tail_q] <= push_arch_i;
      new_q[tail_q]  <= push_new_i;
      prev_q[tail_q] <= push_prev_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i)           tail_q <= nxt(tail_q);
      else if (pop_young_i) tail_q <= young_idx;
      if (pop_old_i)        head_q <= nxt(head_q);
      cnt_q <= cnt_q + NW'(push_i) - NW'(pop_old_i) - NW'(pop_young_i);
    end
  end

  // R3: no record is written into a full log
  a_r3_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R6: walks never retire from an empty log
  a_r6_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_old_i || pop_young_i) |-> !empty_o);
  // R6: young-end retirement never overlaps with appending
  a_r6_pop_push_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pop_young_i && push_i));
endmodule

// File: rtl/rn_rename_map.sv
module rn_rename_map
  import rn_pkg::*;
#(
  parameter int NUM_ARCH   = 8,
  parameter int NUM_PHYS   = 16,
  parameter int HIST_DEPTH = 16,
  parameter int SEQ_W      = 8,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS),
  localparam int CW = $clog2(NUM_PHYS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [SEQ_W-1:0] req_seq_i,
  input  logic [AW-1:0]    req_src0_i,
  input  logic [AW-1:0]    req_src1_i,
  input  logic             req_dst_valid_i,
  input  logic [AW-1:0]    req_dst_i,
  output logic             req_ready_o,
  output logic [PW-1:0]    src0_phys_o,
  output logic             src0_rdy_o,
  output logic [PW-1:0]    src1_phys_o,
  output logic             src1_rdy_o,
  output logic [PW-1:0]    dst_phys_o,
  output logic [PW-1:0]    dst_prev_o,
  input  logic             wb_valid_i,
  input  logic [PW-1:0]    wb_phys_i,
  input  logic             commit_valid_i,
  input  logic [SEQ_W-1:0] commit_seq_i,
  input  logic             squash_valid_i,
  input  logic [SEQ_W-1:0] squash_seq_i,
  output logic             busy_o,
  output logic [CW-1:0]    free_count_o
);
  logic [PW-1:0]    map_q [NUM_ARCH];
  walk_e            walk_q;
  logic [SEQ_W-1:0] walk_seq_q;

  logic             fl_nonempty, h_empty, h_full;
  logic [PW-1:0]    alloc_idx, rel_idx;
  logic             accept, do_alloc, sq_pop, cm_pop;
  logic [SEQ_W-1:0] old_seq, young_seq;
  logic [AW-1:0]    young_arch;
  logic [PW-1:0]    old_prev, young_new, young_prev;

  assign req_ready_o = (walk_q != WALK_SQUASH) && !squash_valid_i && !h_full &&
                       (!req_dst_valid_i || fl_nonempty);
  assign accept      = req_valid_i && req_ready_o;
  assign do_alloc    = accept && req_dst_valid_i;
  assign sq_pop      = (walk_q == WALK_SQUASH) && !h_empty && (young_seq > walk_seq_q);
  assign cm_pop      = (walk_q == WALK_COMMIT) && !h_empty && (old_seq <= walk_seq_q);
  assign rel_idx     = sq_pop ? young_new : old_prev;
  assign busy_o      = (walk_q != WALK_IDLE);

  assign src0_phys_o = map_q[req_src0_i];
  assign src1_phys_o = map_q[req_src1_i];
  assign dst_phys_o  = alloc_idx;
  assign dst_prev_o  = map_q[req_dst_i];

  rn_free_list #(.NUM_PHYS(NUM_PHYS), .NUM_ARCH(NUM_ARCH)) u_free (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_i     (do_alloc),
    .alloc_idx_o (alloc_idx),
    .rel_i       (sq_pop || cm_pop),
    .rel_idx_i   (rel_idx),
    .count_o     (free_count_o),
    .nonempty_o  (fl_nonempty)
  );

  rn_scoreboard #(.NUM_PHYS(NUM_PHYS)) u_sb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (wb_valid_i),
    .set_idx_i (wb_phys_i),
    .clr_i     (do_alloc),
    .clr_idx_i (alloc_idx),
    .rd0_idx_i (src0_phys_o),
    .rd1_idx_i (src1_phys_o),
    .rd0_o     (src0_rdy_o),
    .rd1_o     (src1_rdy_o)
  );

  rn_history #(.DEPTH(HIST_DEPTH), .SEQ_W(SEQ_W), .AW(AW), .PW(PW)) u_hist (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (do_alloc),
    .push_seq_i   (req_seq_i),
    .push_arch_i  (req_dst_i),
    .push_new_i   (alloc_idx),
    .push_prev_i  (dst_prev_o),
    .pop_old_i    (cm_pop),
    .pop_young_i  (sq_pop),
    .old_seq_o    (old_seq),
    .old_prev_o   (old_prev),
    .young_seq_o  (young_seq),
    .young_arch_o (young_arch),
    .young_new_o  (young_new),
    .young_prev_o (young_prev),
    .empty_o      (h_empty),
    .full_o       (h_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_ARCH; i++) map_q[i] <= PW'(i);
    end else if (sq_pop) begin
      map_q[young_arch] <= young_prev;
    end else if (do_alloc) begin
      map_q[req_dst_i] <= alloc_idx;
    end
  end

  // squash outranks commit; commits are dropped while a squash walk runs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      walk_q     <= WALK_IDLE;
      walk_seq_q <= '0;
    end else if (squash_valid_i) begin
      walk_q     <= WALK_SQUASH;
      walk_seq_q <= squash_seq_i;
    end else if (walk_q == WALK_SQUASH) begin
      if (!sq_pop) walk_q <= WALK_IDLE;
    end else if (commit_valid_i) begin
      walk_q     <= WALK_COMMIT;
      walk_seq_q <= commit_seq_i;
    end else if (walk_q == WALK_COMMIT && !cm_pop) begin
      walk_q <= WALK_IDLE;
    end
  end

  // R6: a squash always opens a walk on the next cycle
  a_r6_busy_after_squash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_valid_i |=> busy_o);
  // R9: a commit during a squash walk never starts a commit walk
  a_r9_commit_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !cm_pop && walk_q == WALK_SQUASH && !squash_valid_i && sq_pop) |=>
      (walk_q == WALK_SQUASH));
  // R6: no rename while squash recovery runs
  a_r6_no_alloc_in_squash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sq_pop |-> !do_alloc);
endmodule

// File: tb/rn_rename_map_test.sv
module rn_rename_map_test;
  localparam int CLK_P = 10;
  localparam int AW = 3;
  localparam int PW = 4;
  localparam int CW = 5;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  logic          req_valid = 0, req_dv = 0;
  logic [SW-1:0] req_seq = '0;
  logic [AW-1:0] req_s0 = '0, req_s1 = '0, req_d = '0;
  logic          req_ready, s0_rdy, s1_rdy, busy;
  logic [PW-1:0] s0_p, s1_p, d_p, d_prev;
  logic          wb_valid = 0;
  logic [PW-1:0] wb_phys = '0;
  logic          cm_valid = 0, sq_valid = 0;
  logic [SW-1:0] cm_seq = '0, sq_seq = '0;
  logic [CW-1:0] free_cnt;

  rn_rename_map uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_seq_i(req_seq), .req_src0_i(req_s0),
    .req_src1_i(req_s1), .req_dst_valid_i(req_dv), .req_dst_i(req_d),
    .req_ready_o(req_ready), .src0_phys_o(s0_p), .src0_rdy_o(s0_rdy),
    .src1_phys_o(s1_p), .src1_rdy_o(s1_rdy), .dst_phys_o(d_p), .dst_prev_o(d_prev),
    .wb_valid_i(wb_valid), .wb_phys_i(wb_phys),
    .commit_valid_i(cm_valid), .commit_seq_i(cm_seq),
    .squash_valid_i(sq_valid), .squash_seq_i(sq_seq),
    .busy_o(busy), .free_count_o(free_cnt)
  );

  typedef struct {
    int p0; int r0; int p1; int r1; bit dv; int nw; int prev; string tag;
  } exp_t;
  exp_t exq[$];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: compares each accepted rename against the queued expectation
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      if (exq.size() == 0) begin
        chk(0, "R2 unexpected accept", 1, 0);
      end else begin
        exp_t e;
        e = exq.pop_front();
        chk(int'(s0_p) == e.p0, {e.tag, " src0 phys"}, int'(s0_p), e.p0);
        chk(int'(s0_rdy) == e.r0, {e.tag, " src0 ready"}, int'(s0_rdy), e.r0);
        chk(int'(s1_p) == e.p1, {e.tag, " src1 phys"}, int'(s1_p), e.p1);
        chk(int'(s1_rdy) == e.r1, {e.tag, " src1 ready"}, int'(s1_rdy), e.r1);
        if (e.dv) begin
          chk(int'(d_p) == e.nw, {e.tag, " new phys"}, int'(d_p), e.nw);
          chk(int'(d_prev) == e.prev, {e.tag, " prev phys"}, int'(d_prev), e.prev);
        end
      end
    end
  end

  task automatic rn(input int seq, input int s0, input int s1, input bit dv, input int d,
                    input int p0, input int r0, input int p1, input int r1,
                    input int nw, input int prev, input string tag);
    exp_t e;
    @(posedge clk); #1;
    req_valid = 1; req_seq = SW'(seq); req_s0 = AW'(s0); req_s1 = AW'(s1);
    req_dv = dv; req_d = AW'(d);
    e.p0 = p0; e.r0 = r0; e.p1 = p1; e.r1 = r1; e.dv = dv; e.nw = nw; e.prev = prev;
    e.tag = tag;
    exq.push_back(e);
    @(posedge clk); #1;
    req_valid = 0; req_dv = 0;
  endtask

  task automatic wb(input int p);
    @(posedge clk); #1; wb_valid = 1; wb_phys = PW'(p);
    @(posedge clk); #1; wb_valid = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic squash(input int seq, input bit with_commit);
    @(posedge clk); #1;
    sq_valid = 1; sq_seq = SW'(seq);
    cm_valid = with_commit; cm_seq = SW'(seq);
    @(negedge clk);
    chk(req_ready == 0, "R6 ready low in squash cycle", int'(req_ready), 0);
    @(posedge clk); #1;
    sq_valid = 0; cm_valid = 0;
    @(negedge clk);
    chk(busy == 1, "R6 busy after squash", int'(busy), 1);
    while (busy) @(negedge clk);
  endtask

  task automatic commit(input int seq);
    @(posedge clk); #1; cm_valid = 1; cm_seq = SW'(seq);
    @(posedge clk); #1; cm_valid = 0;
    wait_idle();
  endtask

  task automatic cnt(input int exp, input string tag);
    @(negedge clk);
    chk(int'(free_cnt) == exp, tag, int'(free_cnt), exp);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(int'(free_cnt) == 8, "R1 reset free count", int'(free_cnt), 8);
    chk(busy == 0, "R1 reset busy", int'(busy), 0);
    chk(req_ready == 1, "R1 reset ready", int'(req_ready), 1);

    rn(1, 3, 0, 0, 0, 3, 1, 0, 1, 0, 0, "R1 identity lookup");
    rn(2, 1, 1, 1, 1, 1, 1, 1, 1, 8, 1, "R2 read before own write");
    rn(3, 1, 2, 1, 2, 8, 0, 2, 1, 9, 2, "R3 chained alloc");
    rn(4, 2, 5, 1, 1, 9, 0, 5, 1, 10, 8, "R3 remap same arch");
    cnt(5, "R5 count after three allocs");
    wb(8); wb(10);
    rn(5, 1, 0, 0, 0, 10, 1, 0, 1, 0, 0, "R4 write-back sets ready");

    squash(3, 0);
    cnt(6, "R6 squash frees new register");
    rn(6, 1, 2, 0, 0, 8, 1, 9, 0, 0, 0, "R6 mapping restored");

    commit(2);
    cnt(7, "R7 commit frees displaced register");
    rn(7, 0, 0, 1, 3, 0, 1, 0, 1, 1, 3, "R7 freed register reused");
    cnt(6, "R3 count after alloc");

    commit(2);
    cnt(6, "R8 commit older than oldest ignored");
    rn(8, 2, 3, 0, 0, 9, 0, 1, 0, 0, 0, "R8 map unchanged");

    squash(7, 1);
    cnt(6, "R9 commit with squash ignored");
    rn(9, 2, 3, 0, 0, 9, 0, 1, 0, 0, 0, "R9 map unchanged");

    squash(0, 0);
    cnt(8, "R6 full squash frees all");
    rn(10, 2, 3, 0, 0, 2, 1, 3, 1, 0, 0, "R6 full squash restores");

    squash(0, 0);
    cnt(8, "R10 empty squash count");
    rn(11, 1, 3, 0, 0, 8, 1, 3, 1, 0, 0, "R10 empty squash map");
    commit(20);
    cnt(8, "R8 commit on empty log");

    for (int k = 0; k < 8; k++) begin
      int nw, prev;
      nw = (k == 0) ? 1 : (k == 1) ? 9 : 8 + k;
      prev = (k == 0) ? 4 : (k == 1) ? 1 : (k == 2) ? 9 : 7 + k;
      rn(20 + k, 4, 0, 1, 4, prev, (k == 0) ? 1 : 0, 0, 1, nw, prev, "R3 lowest-first order");
    end
    cnt(0, "R5 pool drained");

    @(posedge clk); #1;
    req_valid = 1; req_dv = 1; req_d = 3; req_seq = 30;
    @(negedge clk);
    chk(req_ready == 0, "R5 stall when pool empty", int'(req_ready), 0);
    @(posedge clk); #1;
    req_valid = 0; req_dv = 0;
    rn(31, 4, 0, 0, 0, 15, 0, 0, 1, 0, 0, "R5 no-dest request accepted");

    repeat (2) @(negedge clk);
    chk(exq.size() == 0, "R2 all expectations consumed", exq.size(), 0);
    done = 1;
    summary();
  end
endmodule